// File: doc/BRIEF.md
# External Bus Handover Arbiter

This block decides when a processor gives its external memory bus to an outside master. The outside master asks for the bus by pulling an active-low request line. The arbiter grants the bus only between external accesses, never in the middle of one. It also grants between two accesses that belong to the same instruction. While the bus is granted, the address, data and strobe pad drivers are turned off.

The core is held in one of two ways. In the normal mode it is stalled for as long as the bus is granted away. In go mode it keeps running and stalls only when its current instruction needs the external bus. If the core is ready to make an access while the bus is away, a separate active-low hung indicator is asserted. When the outside master withdraws its request, the grant and the hung indicator drop together, the drivers come back on, and the pending access proceeds.

The block's own registers use a power-on reset. A separate core reset input only masks the core's access requests, so arbitration keeps working while the processor is held in reset or is booting.

Top module: `xbus_arbiter`

## Requirements
- R1: The request input passes through a SYNC_STAGES-flop synchronizer (default 2). A grant never appears before the (SYNC_STAGES+1)th rising edge after `bus_req_n` falls.
- R2: With no access in progress, `bus_grant_n` goes low on the third rising edge after `bus_req_n` falls (default parameters). `pad_oe` goes low in that same cycle.
- R3: While an external access is in progress (from the edge that accepts `acc_req` until `acc_done`), no grant is given. If the request is pending, the grant becomes active in the cycle right after the cycle in which `acc_done` is high.
- R4: When an instruction makes two external accesses, the grant can be inserted after the first completes and before the second starts.
- R5: On the third rising edge after `bus_req_n` rises, `bus_grant_n`, `bus_hung_n` and `pad_oe` all go high in the same cycle. `pad_oe` is always the inverse of the grant.
- R6: With `go_mode`=0, `core_stall` is high in every cycle in which the bus is granted.
- R7: With `go_mode`=1 and the bus granted, `core_stall` equals (`instr_xcnt` != 0). A count of 0 means the current instruction needs no external access.
- R8: `bus_hung_n` goes low in the cycle after an edge at which the grant is active (or becoming active) while an unmasked `acc_req` is high. It is only low while the bus is granted.
- R9: When the grant is released with `acc_req` still high, `core_stall` is low in that cycle and the access is accepted at the next edge.
- R10: While `core_rst` is high, grants still follow `bus_req_n`. `acc_req` is ignored: no access starts and `bus_hung_n` stays high.
- R11: If the bus is idle, the synchronized request is active and `acc_req` is high, the external master wins. `core_stall` is high, and the grant follows at the next edge.
- R12: After `rst_n` the outputs are: `bus_grant_n`=1, `bus_hung_n`=1, `pad_oe`=1, `core_stall`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset of the arbiter registers, active low, asynchronous |
| bus_req_n | input | 1 | Bus request from the outside master, active low, asynchronous |
| core_rst | input | 1 | Processor core reset; masks access requests only |
| acc_req | input | 1 | Core is ready to start an external access |
| acc_done | input | 1 | Strobe: the access in progress completes this cycle |
| instr_xcnt | input | CNT_W | Number of external accesses the current instruction needs |
| go_mode | input | 1 | 1: keep the core running while the bus is granted |
| bus_grant_n | output | 1 | Bus grant to the outside master, active low |
| bus_hung_n | output | 1 | Core waiting on a granted bus, active low |
| pad_oe | output | 1 | Output enable for the address, data and strobe drivers |
| core_stall | output | 1 | Halts the core |

## Verification
The bench builds the block with SYNC_STAGES=2 and CNT_W=2. With these values the three-edge latency of a request and of a release can be counted exactly. The count field can describe instructions with zero to three accesses, which covers the two-access instruction and the go-mode case where no access is needed. A random phase changes the request, go mode and core reset around accesses of random length, against a cycle model written from the requirements. Directed cases pin down the access boundary, the release with a pending access and the priority at idle.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef struct packed {
        logic grant;   // bus handed to outside master
        logic busy;    // external access in flight
        logic hung;    // core waiting on granted bus
    } arb_state_t;

    localparam arb_state_t ARB_RESET = '{grant: 1'b0, busy: 1'b0, hung: 1'b0};

endpackage

// File: rtl/xbus_req_sync.sv
module xbus_req_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_req_n,
    output logic req_o
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    // first stage samples the inverted (active-high) request
    assign chain_d[0] = ~async_req_n;

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            assign chain_d[i] = chain_q[i-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign req_o = chain_q[STAGES-1];

endmodule

// File: rtl/xbus_arb_fsm.sv
module xbus_arb_fsm
    import xbus_pkg::*;
#(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_s,
    input  logic             acc_req,
    input  logic             acc_done,
    input  logic [CNT_W-1:0] instr_xcnt,
    input  logic             go_mode,
    input  logic             core_rst,
    output logic             grant_o,
    output logic             grant_next_o,
    output logic             hung_o,
    output logic             busy_o,
    output logic             stall_o
);

    arb_state_t st_d;
    arb_state_t st_q;
    logic       acc_eff;
    logic       need_bus;
    logic       stall_d;

    always_comb begin
        acc_eff  = acc_req & ~core_rst;
        need_bus = (instr_xcnt != '0);
        st_d     = st_q;

        if (st_q.busy) begin
            // access boundary: grant only once the access finishes
            st_d.busy  = ~acc_done;
            st_d.grant = req_s & acc_done;
        end else if (st_q.grant) begin
            st_d.busy  = 1'b0;
            st_d.grant = req_s;
        end else if (req_s) begin
            // outside master wins over a fresh core access
            st_d.grant = 1'b1;
        end else begin
            st_d.busy  = acc_eff;
        end

        st_d.hung = st_d.grant & acc_eff;

        if (st_q.grant) begin
            stall_d = go_mode ? need_bus : 1'b1;
        end else begin
            stall_d = acc_eff & ~st_q.busy & req_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ARB_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o      = st_q.grant;
    assign grant_next_o = st_d.grant;
    assign hung_o       = st_q.hung;
    assign busy_o       = st_q.busy;
    assign stall_o      = stall_d;

endmodule

// File: rtl/xbus_pad_ctl.sv
module xbus_pad_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic grant_next,
    output logic pad_oe
);

    logic oe_d;
    logic oe_q;

    always_comb begin
        oe_d = ~grant_next;
    end

    // separate flop placed near the pad ring
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q <= 1'b1;
        end else begin
            oe_q <= oe_d;
        end
    end

    assign pad_oe = oe_q;

endmodule

// File: rtl/xbus_arbiter.sv
module xbus_arbiter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req_n,
    input  logic             core_rst,
    input  logic             acc_req,
    input  logic             acc_done,
    input  logic [CNT_W-1:0] instr_xcnt,
    input  logic             go_mode,
    output logic             bus_grant_n,
    output logic             bus_hung_n,
    output logic             pad_oe,
    output logic             core_stall
);

    logic req_s;
    logic grant;
    logic grant_next;
    logic hung;
    logic busy;

    xbus_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .async_req_n (bus_req_n),
        .req_o       (req_s)
    );

    xbus_arb_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_s        (req_s),
        .acc_req      (acc_req),
        .acc_done     (acc_done),
        .instr_xcnt   (instr_xcnt),
        .go_mode      (go_mode),
        .core_rst     (core_rst),
        .grant_o      (grant),
        .grant_next_o (grant_next),
        .hung_o       (hung),
        .busy_o       (busy),
        .stall_o      (core_stall)
    );

    xbus_pad_ctl u_pad (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant_next (grant_next),
        .pad_oe     (pad_oe)
    );

    assign bus_grant_n = ~grant;
    assign bus_hung_n  = ~hung;

endmodule

// File: rtl/xbus_arbiter_chk.sv
module xbus_arbiter_chk #(
    parameter int unsigned CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_s,
    input logic             busy,
    input logic             acc_done,
    input logic             go_mode,
    input logic [CNT_W-1:0] instr_xcnt,
    input logic             bus_grant_n,
    input logic             bus_hung_n,
    input logic             pad_oe,
    input logic             core_stall
);

    // R1
    grant_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_grant_n) |-> $past(req_s));

    // R3
    no_grant_mid_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !acc_done) |=> bus_grant_n);

    // R5
    pad_follows_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe == bus_grant_n);

    // R5
    hung_drops_with_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_grant_n) |-> bus_hung_n);

    // R6
    stall_while_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!go_mode && !bus_grant_n) |-> core_stall);

    // R7
    go_runs_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_mode && !bus_grant_n && instr_xcnt == '0) |-> !core_stall);

    // R8
    hung_only_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_hung_n |-> !bus_grant_n);

endmodule

bind xbus_arbiter xbus_arbiter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_s       (req_s),
    .busy        (busy),
    .acc_done    (acc_done),
    .go_mode     (go_mode),
    .instr_xcnt  (instr_xcnt),
    .bus_grant_n (bus_grant_n),
    .bus_hung_n  (bus_hung_n),
    .pad_oe      (pad_oe),
    .core_stall  (core_stall)
);

// File: tb/tb_xbus_arbiter.sv
module tb_xbus_arbiter;

    localparam int unsigned SYNC_STAGES = 2;
    localparam int unsigned CNT_W       = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_req_n = 1'b1;
    logic             core_rst = 1'b0;
    logic             acc_req = 1'b0;
    logic             acc_done = 1'b0;
    logic [CNT_W-1:0] instr_xcnt = '0;
    logic             go_mode = 1'b0;
    logic             bus_grant_n;
    logic             bus_hung_n;
    logic             pad_oe;
    logic             core_stall;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model state
    bit m_rq [SYNC_STAGES];
    bit m_grant, m_busy, m_hung;

    always #5 clk = ~clk;

    xbus_arbiter #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) dut (
        .clk, .rst_n, .bus_req_n, .core_rst, .acc_req, .acc_done,
        .instr_xcnt, .go_mode, .bus_grant_n, .bus_hung_n, .pad_oe, .core_stall
    );

    task automatic expect_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_stall();
        bit eff;
        eff = acc_req && !core_rst;
        if (m_grant) return go_mode ? (instr_xcnt != 0) : 1'b1;
        return eff && !m_busy && m_rq[SYNC_STAGES-1];
    endfunction

    task automatic mdl_reset();
        for (int i = 0; i < SYNC_STAGES; i++) m_rq[i] = 1'b0;
        m_grant = 1'b0; m_busy = 1'b0; m_hung = 1'b0;
    endtask

    task automatic mdl_update();
        bit rs, eff, g, b;
        rs  = m_rq[SYNC_STAGES-1];
        eff = acc_req && !core_rst;
        if (m_busy) begin
            g = rs && acc_done; b = !acc_done;
        end else if (m_grant || rs) begin
            g = rs; b = 1'b0;
        end else begin
            g = 1'b0; b = eff;
        end
        m_grant = g; m_busy = b; m_hung = g && eff;
        for (int i = SYNC_STAGES - 1; i > 0; i--) m_rq[i] = m_rq[i-1];
        m_rq[0] = !bus_req_n;
    endtask

    task automatic mdl_check();
        expect_bit(bus_grant_n, !m_grant, "R3 grant");
        expect_bit(pad_oe, !m_grant, "R5 pad_oe");
        expect_bit(bus_hung_n, !m_hung, "R8 hung");
        expect_bit(core_stall, exp_stall(), go_mode ? "R7 stall" : "R6 stall");
    endtask

    task automatic tick();
        @(posedge clk);
        mdl_update();
        @(negedge clk);
        #1;
        mdl_check();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        process_setup();
        run_directed();
        run_random();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic process_setup();
        void'($urandom(32'd1234));
        mdl_reset();
        repeat (3) @(negedge clk);
        #1;
        // R12 reset values
        expect_bit(bus_grant_n, 1'b1, "R12 grant_n");
        expect_bit(bus_hung_n, 1'b1, "R12 hung_n");
        expect_bit(pad_oe, 1'b1, "R12 pad_oe");
        expect_bit(core_stall, 1'b0, "R12 stall");
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_directed();
        // R1 / R2: idle grant latency
        bus_req_n = 1'b0;
        tick(); expect_bit(bus_grant_n, 1'b1, "R1 edge1");
        tick(); expect_bit(bus_grant_n, 1'b1, "R1 edge2");
        tick(); expect_bit(bus_grant_n, 1'b0, "R2 edge3 grant");
        expect_bit(pad_oe, 1'b0, "R2 edge3 pad_oe");
        bus_req_n = 1'b1;
        ticks(3);
        expect_bit(bus_grant_n, 1'b1, "R5 release");
        ticks(2);

        // R3 / R4: request during the first of two accesses
        instr_xcnt = 2'd2; acc_req = 1'b1;
        tick(); acc_req = 1'b0;
        bus_req_n = 1'b0;
        ticks(4);
        expect_bit(bus_grant_n, 1'b1, "R3 held during access");
        acc_done = 1'b1;
        tick(); acc_done = 1'b0;
        expect_bit(bus_grant_n, 1'b0, "R3 grant after done");
        acc_req = 1'b1;  // second access of the instruction
        #1;
        expect_bit(core_stall, 1'b1, "R4 second access stalled");
        tick();
        expect_bit(bus_hung_n, 1'b0, "R8 hung asserted");
        bus_req_n = 1'b1;
        ticks(2);
        expect_bit(bus_grant_n, 1'b0, "R5 still granted");
        tick();
        expect_bit(bus_grant_n, 1'b1, "R5 grant released");
        expect_bit(bus_hung_n, 1'b1, "R5 hung released");
        expect_bit(pad_oe, 1'b1, "R5 drivers on");
        expect_bit(core_stall, 1'b0, "R9 core resumes");
        tick(); acc_req = 1'b0;
        acc_done = 1'b1; tick(); acc_done = 1'b0;
        instr_xcnt = 2'd0;

        // R7: go mode
        go_mode = 1'b1; bus_req_n = 1'b0;
        ticks(3);
        expect_bit(core_stall, 1'b0, "R7 runs while granted");
        instr_xcnt = 2'd1; #1;
        expect_bit(core_stall, 1'b1, "R7 stalls on access instr");
        acc_req = 1'b1;
        tick();
        expect_bit(bus_hung_n, 1'b0, "R8 hung in go mode");
        bus_req_n = 1'b1;
        ticks(3);
        tick(); acc_req = 1'b0;
        acc_done = 1'b1; tick(); acc_done = 1'b0;
        go_mode = 1'b0; instr_xcnt = 2'd0;

        // R10: core reset keeps arbitration, masks access
        core_rst = 1'b1; instr_xcnt = 2'd1; acc_req = 1'b1;
        bus_req_n = 1'b0;
        tick();
        expect_bit(core_stall, 1'b0, "R10 no access started");
        ticks(2);
        expect_bit(bus_grant_n, 1'b0, "R10 grant in reset");
        tick();
        expect_bit(bus_hung_n, 1'b1, "R10 hung masked");
        bus_req_n = 1'b1;
        ticks(3);
        acc_req = 1'b0; core_rst = 1'b0; instr_xcnt = 2'd0;
        ticks(2);

        // R11: request wins over a fresh access at idle
        bus_req_n = 1'b0;
        ticks(2);
        acc_req = 1'b1; instr_xcnt = 2'd1; #1;
        expect_bit(core_stall, 1'b1, "R11 core loses");
        tick();
        expect_bit(bus_grant_n, 1'b0, "R11 master wins");
        bus_req_n = 1'b1;
        ticks(3);
        tick(); acc_req = 1'b0;
        acc_done = 1'b1; tick(); acc_done = 1'b0;
        instr_xcnt = 2'd0;
        ticks(2);
    endtask

    task automatic run_random();
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(7) == 0) bus_req_n = ~bus_req_n;
            if ($urandom_range(199) == 0) go_mode = ~go_mode;
            if ($urandom_range(99) == 0) core_rst = ~core_rst;
            if (m_busy) begin
                acc_req  = 1'b0;
                acc_done = ($urandom_range(2) == 0);
            end else begin
                acc_done = 1'b0;
                if (!acc_req) begin
                    if ($urandom_range(3) == 0) begin
                        acc_req    = 1'b1;
                        instr_xcnt = CNT_W'($urandom_range(3, 1));
                    end else if ($urandom_range(5) == 0) begin
                        instr_xcnt = CNT_W'($urandom_range(3));
                    end
                end
            end
            tick();
        end
    endtask

endmodule